// File: doc/BRIEF.md
# Power-Budgeted Action Scheduler

This block is the per-cycle control circuit for a design described as a set of guarded actions. On every clock it looks at which actions have a true guard, drops the lower-priority member of every conflicting pair, and places the surviving set into an execution order. It then grants actions from the front of that order while the summed weight stays within a peak budget. Each action's weight is an estimate of the power its body draws.

Actions that do not fit in the current cycle are kept and drained over the following cycles. While any are still pending, the ready inputs are not looked at. The cycle that samples a fresh ready set is marked with a synchronisation pulse. At that point the schedule has caught up with one that fires every non-conflicting ready action at once. The conflict matrix, precedence matrix, urgencies and weights are meant to be held static by the surrounding logic.

Top module: `budget_action_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant` is zero, `grant_weight` is zero, `sync_pt` is low and nothing is pending.
- R2: On a sampling cycle, each ready action is visited in priority order: higher `urgency` first, and on equal urgency the lower index first. It is selected only if it conflicts with no action already selected. Bit i*N_ACT+j or bit j*N_ACT+i of `conflict_m` marks actions i and j as conflicting.
- R3: Whenever more than one action is granted in a cycle, the summed weight of the granted actions is at most `budget`.
- R4: The selected set is ordered by repeatedly taking the lowest-index remaining action that has no remaining predecessor. Bit a*N_ACT+b of `precede` set means a comes before b, and the diagonal is ignored. If every remaining action has a predecessor, the lowest-index remaining action is taken.
- R5: Grants form a prefix of the order. Granting stops at the first action that would push the running total above `budget`, even if a later action would fit.
- R6: The first action of the order is always granted, even when its weight alone exceeds `budget`, so a non-empty set always makes progress.
- R7: Actions left over are granted in later cycles, in the same order. The `ready` inputs have no effect until none are left.
- R8: `sync_pt` is high exactly in the output cycle after a decision that sampled `ready`. That is any decision made with nothing pending. All outputs are registered, one clock after the inputs they depend on.
- R9: `grant_weight` equals the sum of the weights of the actions set in `grant`, and is zero when nothing is granted.
- R10: Take weights 4, 3, 4 for actions 0, 1, 2, with action 1 ordered before action 0 and a budget of 5. If actions 0 and 1 are ready, action 1 is granted alone (weight 3) and action 0 follows alone in the next cycle (weight 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | input | N_ACT | Guard-true bit per action |
| conflict_m | input | N_ACT*N_ACT | Pairwise conflict matrix, bit i*N_ACT+j |
| precede | input | N_ACT*N_ACT | Pairwise ordering matrix, bit a*N_ACT+b means a before b |
| urgency | input | N_ACT*URG_W | Per-action urgency, action i in bits [i*URG_W +: URG_W] |
| weight | input | N_ACT*W_W | Per-action power weight, action i in bits [i*W_W +: W_W] |
| budget | input | SUM_W | Peak summed weight per cycle |
| grant | output | N_ACT | Fire enable per action, registered |
| grant_weight | output | SUM_W | Summed weight of this cycle's grants, registered |
| sync_pt | output | 1 | Synchronisation-point pulse, registered |

## Verification
The bench targets a zero budget and a single action heavier than the budget. A design that gates the first grant by weight would stall forever there. Another target is an order in which a small action sits behind one that does not fit. A design that skips ahead would grant the small action early and break the prefix rule. Ready bits are changed while leftovers drain, so a design that re-samples too early shows an extra grant and a stray synchronisation pulse. Ties in urgency and chains of conflicts expose a wrong tie rule or a non-greedy selection, which would grant the wrong member of a pair.

// File: rtl/sched_pkg.sv
package sched_pkg;
   localparam int unsigned SCHED_MAX_ACT = 8;

   // true when candidate a outranks candidate b
   function automatic logic outranks(input int unsigned ua, input int unsigned ub,
                                     input int unsigned ia, input int unsigned ib);
      return (ua > ub) || ((ua == ub) && (ia < ib));
   endfunction
endpackage

// File: rtl/sched_conflict_pick.sv
module sched_conflict_pick
   import sched_pkg::*;
#(
   parameter int N_ACT = 4,
   parameter int URG_W = 3
) (
   input  logic [N_ACT-1:0]       ready,
   input  logic [N_ACT*N_ACT-1:0] conflict_m,
   input  logic [N_ACT*URG_W-1:0] urgency,
   output logic [N_ACT-1:0]       keep
);
   localparam int RK_W = $clog2(N_ACT) + 1;

   logic [URG_W-1:0] urg   [N_ACT];
   logic [N_ACT-1:0] clash [N_ACT];
   logic [RK_W-1:0]  rank  [N_ACT];

   genvar gi, gj;
   generate
      for (gi = 0; gi < N_ACT; gi++) begin : g_row
         assign urg[gi] = urgency[gi*URG_W +: URG_W];
         for (gj = 0; gj < N_ACT; gj++) begin : g_col
            if (gi == gj) begin : g_diag
               assign clash[gi][gj] = 1'b0;
            end else begin : g_off
               assign clash[gi][gj] = conflict_m[gi*N_ACT+gj] | conflict_m[gj*N_ACT+gi];
            end
         end
      end
   endgenerate

   // position of each action in the priority order
   always_comb begin
      for (int i = 0; i < N_ACT; i++) begin
         rank[i] = '0;
         for (int j = 0; j < N_ACT; j++) begin
            if (j != i && outranks(int'(urg[j]), int'(urg[i]), j, i))
               rank[i] = rank[i] + RK_W'(1);
         end
      end
   end

   // greedy walk in priority order
   always_comb begin
      logic [N_ACT-1:0] kept;
      kept = '0;
      for (int pos = 0; pos < N_ACT; pos++) begin
         for (int i = 0; i < N_ACT; i++) begin
            if (rank[i] == RK_W'(pos) && ready[i] && ((clash[i] & kept) == '0))
               kept[i] = 1'b1;
         end
      end
      keep = kept;
   end
endmodule

// File: rtl/sched_order_gate.sv
module sched_order_gate #(
   parameter int N_ACT = 4,
   parameter int W_W   = 4,
   parameter int SUM_W = 7
) (
   input  logic [N_ACT-1:0]       cand,
   input  logic [N_ACT*N_ACT-1:0] precede,
   input  logic [N_ACT*W_W-1:0]   weight,
   input  logic [SUM_W-1:0]       budget,
   output logic [N_ACT-1:0]       grant,
   output logic [SUM_W-1:0]       wsum
);
   localparam int IDX_W = (N_ACT > 1) ? $clog2(N_ACT) : 1;

   logic [W_W-1:0]   wt   [N_ACT];
   logic [N_ACT-1:0] pred [N_ACT];   // pred[b][a]: a must precede b

   genvar gi, gj;
   generate
      for (gi = 0; gi < N_ACT; gi++) begin : g_act
         assign wt[gi] = weight[gi*W_W +: W_W];
         for (gj = 0; gj < N_ACT; gj++) begin : g_pred
            if (gi == gj) begin : g_self
               assign pred[gi][gj] = 1'b0;
            end else begin : g_other
               assign pred[gi][gj] = precede[gj*N_ACT+gi];
            end
         end
      end
   endgenerate

   always_comb begin
      logic [N_ACT-1:0] remain;
      logic [SUM_W-1:0] run;
      logic [IDX_W-1:0] pick;
      logic             found;
      logic             halted;
      logic             first;
      remain = cand;
      run    = '0;
      halted = 1'b0;
      first  = 1'b1;
      grant  = '0;
      for (int step = 0; step < N_ACT; step++) begin
         found = 1'b0;
         pick  = '0;
         for (int i = 0; i < N_ACT; i++) begin
            if (!found && remain[i] && ((pred[i] & remain) == '0)) begin
               found = 1'b1;
               pick  = IDX_W'(i);
            end
         end
         // cyclic precedence: fall back to lowest index
         for (int i = 0; i < N_ACT; i++) begin
            if (!found && remain[i]) begin
               found = 1'b1;
               pick  = IDX_W'(i);
            end
         end
         if (found) begin
            remain[pick] = 1'b0;
            if (!halted) begin
               if (first || (run + SUM_W'(wt[pick]) <= budget)) begin
                  grant[pick] = 1'b1;
                  run         = run + SUM_W'(wt[pick]);
                  first       = 1'b0;
               end else begin
                  halted = 1'b1;
               end
            end
         end
      end
      wsum = run;
   end
endmodule

// File: rtl/budget_action_sched.sv
module budget_action_sched
   import sched_pkg::*;
#(
   parameter  int N_ACT = 4,
   parameter  int W_W   = 4,
   parameter  int URG_W = 3,
   localparam int SUM_W = W_W + $clog2(N_ACT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_ACT-1:0]       ready,
   input  logic [N_ACT*N_ACT-1:0] conflict_m,
   input  logic [N_ACT*N_ACT-1:0] precede,
   input  logic [N_ACT*URG_W-1:0] urgency,
   input  logic [N_ACT*W_W-1:0]   weight,
   input  logic [SUM_W-1:0]       budget,
   output logic [N_ACT-1:0]       grant,
   output logic [SUM_W-1:0]       grant_weight,
   output logic                   sync_pt
);
   initial begin : param_chk
      if (N_ACT < 2 || N_ACT > int'(SCHED_MAX_ACT))
         $error("N_ACT must lie in 2..%0d", SCHED_MAX_ACT);
      if (W_W < 1 || URG_W < 1)
         $error("weight and urgency widths must be positive");
   end

   logic [N_ACT-1:0] pend_q;
   logic [N_ACT-1:0] sel_c;
   logic [N_ACT-1:0] cand_c;
   logic [N_ACT-1:0] grant_c;
   logic [SUM_W-1:0] wsum_c;
   logic             fresh_c;

   sched_conflict_pick #(.N_ACT(N_ACT), .URG_W(URG_W)) u_pick (
      .ready      (ready),
      .conflict_m (conflict_m),
      .urgency    (urgency),
      .keep       (sel_c)
   );

   assign fresh_c = (pend_q == '0);
   assign cand_c  = fresh_c ? sel_c : pend_q;

   sched_order_gate #(.N_ACT(N_ACT), .W_W(W_W), .SUM_W(SUM_W)) u_gate (
      .cand    (cand_c),
      .precede (precede),
      .weight  (weight),
      .budget  (budget),
      .grant   (grant_c),
      .wsum    (wsum_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q       <= '0;
         grant        <= '0;
         grant_weight <= '0;
         sync_pt      <= 1'b0;
      end else begin
         pend_q       <= cand_c & ~grant_c;
         grant        <= grant_c;
         grant_weight <= wsum_c;
         sync_pt      <= fresh_c;
      end
   end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
   parameter int N_ACT = 4,
   parameter int W_W   = 4,
   localparam int SUM_W = W_W + $clog2(N_ACT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_ACT-1:0] ready,
   input logic [SUM_W-1:0] budget,
   input logic [N_ACT-1:0] grant,
   input logic [SUM_W-1:0] grant_weight,
   input logic             sync_pt,
   input logic [N_ACT-1:0] pend
);
   // R3: several grants never exceed the budget in force at the decision
   p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(grant) > 1) |-> (grant_weight <= $past(budget)));

   // R6: a fresh, non-empty ready set always yields a grant
   p_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pt && ($past(ready) != '0)) |-> (grant != '0));

   // R7: no sampling while leftovers remain
   p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |=> !sync_pt);

   // R7: granted actions are never also pending
   p_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & pend) == '0);

   // R8: an empty leftover set leads to a sampling cycle
   p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> sync_pt);

   // R8: a sampling cycle grants only actions that were ready
   p_sync_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pt |-> ((grant & ~$past(ready)) == '0));

   // R9: no grant carries no weight
   p_idle_weight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |-> (grant_weight == '0));
endmodule

bind budget_action_sched sched_checker #(.N_ACT(N_ACT), .W_W(W_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ready        (ready),
   .budget       (budget),
   .grant        (grant),
   .grant_weight (grant_weight),
   .sync_pt      (sync_pt),
   .pend         (pend_q)
);

// File: tb/budget_action_sched_test.sv
module budget_action_sched_test;
   localparam int NA     = 4;
   localparam int WW     = 4;
   localparam int UW     = 3;
   localparam int SW     = WW + $clog2(NA + 1);
   localparam int CLK_PS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NA-1:0]    ready_i = '0;
   logic [NA*NA-1:0] conf_i = '0;
   logic [NA*NA-1:0] prec_i = '0;
   logic [NA*UW-1:0] urg_i = '0;
   logic [NA*WW-1:0] wt_i = '0;
   logic [SW-1:0]    bud_i = '0;
   logic [NA-1:0]    grant_o;
   logic [SW-1:0]    wsum_o;
   logic             sync_o;

   always #(CLK_PS/2) clk = ~clk;

   budget_action_sched #(.N_ACT(NA), .W_W(WW), .URG_W(UW)) uut (
      .clk(clk), .rst_n(rst_n), .ready(ready_i), .conflict_m(conf_i),
      .precede(prec_i), .urgency(urg_i), .weight(wt_i), .budget(bud_i),
      .grant(grant_o), .grant_weight(wsum_o), .sync_pt(sync_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit [NA-1:0] rdy;
   int wt [NA];
   int urg[NA];
   bit cf [NA][NA];
   bit pr [NA][NA];
   int bud;
   int pq[$];

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < NA; i++) begin
         ready_i[i] = rdy[i];
         urg_i[i*UW +: UW] = UW'(urg[i]);
         wt_i[i*WW +: WW]  = WW'(wt[i]);
         for (int j = 0; j < NA; j++) begin
            conf_i[i*NA+j] = cf[i][j];
            prec_i[i*NA+j] = pr[i][j];
         end
      end
      bud_i = SW'(bud);
   endtask

   // behavioural reference of one decision
   task automatic model(output int eg, output int ew, output bit es);
      eg = 0; ew = 0;
      es = (pq.size() == 0);
      if (es) begin
         bit used[NA];
         bit kept[NA];
         bit rem[NA];
         int pri[$];
         for (int i = 0; i < NA; i++) begin used[i] = 0; kept[i] = 0; end
         for (int p = 0; p < NA; p++) begin
            int best = -1;
            for (int i = 0; i < NA; i++)
               if (!used[i] && (best < 0 || urg[i] > urg[best])) best = i;
            used[best] = 1;
            pri.push_back(best);
         end
         foreach (pri[k]) begin
            int a = pri[k];
            bit ok = rdy[a];
            for (int b = 0; b < NA; b++)
               if (b != a && kept[b] && (cf[a][b] || cf[b][a])) ok = 0;
            kept[a] = ok;
         end
         for (int i = 0; i < NA; i++) rem[i] = kept[i];
         for (int s = 0; s < NA; s++) begin
            int pk = -1;
            for (int i = 0; i < NA && pk < 0; i++) begin
               if (rem[i]) begin
                  bit free = 1;
                  for (int j = 0; j < NA; j++)
                     if (j != i && rem[j] && pr[j][i]) free = 0;
                  if (free) pk = i;
               end
            end
            for (int i = 0; i < NA && pk < 0; i++) if (rem[i]) pk = i;
            if (pk >= 0) begin rem[pk] = 0; pq.push_back(pk); end
         end
      end
      begin
         bit first = 1;
         while (pq.size() > 0) begin
            int a = pq[0];
            if (first || ew + wt[a] <= bud) begin
               eg |= (1 << a);
               ew += wt[a];
               first = 0;
               void'(pq.pop_front());
            end else break;
         end
      end
   endtask

   int last_g, last_w;
   bit last_s;

   // apply inputs at a falling edge, compare after the next rising edge
   task automatic step(input string req);
      int eg, ew;
      bit es;
      drive();
      model(eg, ew, es);
      @(posedge clk);
      @(negedge clk);
      check(req, int'(grant_o), eg, "grant");
      check(req, int'(wsum_o), ew, "grant_weight");
      check("R8", int'(sync_o), int'(es), "sync_pt");
      last_g = int'(grant_o); last_w = int'(wsum_o); last_s = sync_o;
   endtask

   task automatic clear_cfg();
      rdy = '0; bud = 15;
      for (int i = 0; i < NA; i++) begin
         wt[i] = 1; urg[i] = 0;
         for (int j = 0; j < NA; j++) begin cf[i][j] = 0; pr[i][j] = 0; end
      end
   endtask

   task automatic flush();
      rdy = '0;
      while (pq.size() > 0) step("R7");
      step("R8");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      clear_cfg();
      drive();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", int'(grant_o), 0, "grant in reset");
      check("R1", int'(wsum_o), 0, "grant_weight in reset");
      check("R1", int'(sync_o), 0, "sync_pt in reset");
      rst_n = 1'b1;
      step("R1");
      check("R1", last_g, 0, "first grant after reset");

      // R10: weights 4,3,4, action 1 before action 0, budget 5
      clear_cfg();
      wt[0] = 4; wt[1] = 3; wt[2] = 4; wt[3] = 1;
      cf[0][2] = 1; cf[2][0] = 1;
      pr[1][0] = 1;
      bud = 5; rdy = 4'b0011;
      step("R10");
      check("R10", last_g, 2, "first cycle grant");
      check("R10", last_w, 3, "first cycle weight");
      rdy = 4'b0101;   // must be ignored while draining (R7)
      step("R7");
      check("R10", last_g, 1, "second cycle grant");
      check("R10", last_w, 4, "second cycle weight");
      check("R7", int'(last_s), 0, "no sampling during drain");
      flush();

      // R2: higher urgency wins a conflict
      clear_cfg();
      cf[0][2] = 1; urg[2] = 5; urg[0] = 2; rdy = 4'b0101;
      step("R2");
      check("R2", last_g, 4, "urgent action kept");
      // R2: equal urgency keeps lower index
      urg[2] = 2;
      step("R2");
      check("R2", last_g, 1, "tie keeps lower index");
      // R2: conflict chain, greedy by priority
      clear_cfg();
      cf[0][1] = 1; cf[1][2] = 1; rdy = 4'b0111;
      step("R2");
      check("R2", last_g, 5, "chain with equal urgency");
      urg[1] = 7;
      step("R2");
      check("R2", last_g, 2, "chain with urgent middle");

      // R6: oversize single action
      clear_cfg();
      wt[0] = 12; bud = 5; rdy = 4'b0001;
      step("R6");
      check("R6", last_g, 1, "oversize granted alone");
      check("R9", last_w, 12, "oversize weight");
      flush();

      // R5: no skipping past an action that does not fit
      clear_cfg();
      wt[0] = 3; wt[1] = 4; wt[2] = 1;
      pr[0][1] = 1; pr[1][2] = 1; bud = 5; rdy = 4'b0111;
      step("R5");
      check("R5", last_g, 1, "prefix grant");
      step("R5");
      check("R5", last_g, 6, "remainder grant");
      flush();

      // R4: precedence puts a higher index first
      clear_cfg();
      pr[3][0] = 1; pr[2][3] = 1; bud = 0; rdy = 4'b1101;
      step("R4"); check("R4", last_g, 4, "order first");
      step("R4"); check("R4", last_g, 8, "order second");
      step("R3"); check("R3", last_g, 1, "zero budget single grant");
      flush();

      // random traffic against the reference
      for (int n = 0; n < 400; n++) begin
         if (n % 50 == 0) begin
            for (int i = 0; i < NA; i++) begin
               wt[i]  = 1 + int'($urandom_range(0, 9));
               urg[i] = int'($urandom_range(0, 3));
               for (int j = 0; j < NA; j++) begin
                  if (j > i) begin
                     cf[i][j] = ($urandom_range(0, 2) == 0);
                     cf[j][i] = cf[i][j];
                  end
                  pr[i][j] = (i != j) && ($urandom_range(0, 3) == 0);
               end
            end
         end
         rdy = NA'($urandom_range(0, 15));
         bud = int'($urandom_range(0, 20));
         step(pq.size() == 0 ? "R9" : "R7");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule